// File: doc/BRIEF.md
# Transmit Timestamp Capture Register

This block records the network time at the moment a transmitted frame passes the capture point. The capture happens only when that frame's transmit descriptor asked for a timestamp. The seconds and nanoseconds values from the running time counter are latched together into a holding pair. Host software reads that pair through a small register read port and forms the full time as seconds × 1e9 + nanoseconds.

The top bit of the nanoseconds word is an availability flag. While it is set, the held value is not a fresh capture and software must not use it. A configuration input picks how an unread capture is handled when a newer request arrives:
- Overwrite mode replaces the unread capture with the newer one.
- Keep mode drops the newer request and sets a sticky drop flag.

Software consumes a capture by reading the nanoseconds word and then the seconds word.

Top module: `tx_ts_capture`

## Requirements
- R1: After reset the nanoseconds word reads 32'h8000_0000. Bit 31 is the availability flag (1 = nothing fresh), bit 30 is the drop flag, bits 29:0 are nanoseconds, and the seconds word reads 0.
- R2: A start-of-frame strobe whose request flag (descriptor word 2, bit 30) is clear leaves both words unchanged.
- R3: A strobe with the request flag set latches seconds and nanoseconds from that same cycle. From the next cycle the seconds word (`rd_sel_i` = 1) returns the seconds, the nanoseconds word (`rd_sel_i` = 0) returns the nanoseconds in bits 29:0, and bit 31 reads 0.
- R4: With `overwrite_i` = 1, a capture request while a capture is unread replaces the held value and does not set the drop flag.
- R5: With `overwrite_i` = 0, a capture request while a capture is unread leaves the held value unchanged and sets the drop flag.
- R6: A seconds-word read that directly follows a nanoseconds-word read consumes the capture. After that, bit 31 reads 1, the drop flag reads 0, and the held time stays readable.
- R7: A seconds-word read that is not preceded by a nanoseconds-word read does not consume the capture.
- R8: A capture accepted between the nanoseconds read and the seconds read cancels the pairing, so that seconds read does not consume.
- R9: In keep mode, a capture request in the same cycle as a consuming seconds read is accepted, and the drop flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| time_sec_i | input | SEC_W | Current seconds from the time counter |
| time_nsec_i | input | NS_W | Current nanoseconds from the time counter |
| sof_i | input | 1 | Start-of-frame strobe at the capture point |
| ts_req_i | input | 1 | Frame's timestamp request (descriptor word 2, bit 30) |
| overwrite_i | input | 1 | 1 = newer capture replaces unread one, 0 = keep older |
| rd_en_i | input | 1 | Host read strobe |
| rd_sel_i | input | 1 | 0 = nanoseconds word, 1 = seconds word |
| rd_data_o | output | DATA_W | Read data for the selected word |

## Verification
If the held pair loads from the wrong cycle or under the wrong policy, the very next read of either word shows a value different from the time driven with the strobe. If the availability or drop state is wrong, bit 31 or bit 30 of the next nanoseconds read is off. A pairing tracker that is out of step shows up only one read later: bit 31 fails to rise, or rises too early, on the nanoseconds read that follows a seconds read. The bench therefore always ends each scenario with that follow-up read.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic {
        SEL_NSEC = 1'b0,
        SEL_SEC  = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/tsc_hold.sv
module tsc_hold #(
    parameter int SEC_W = 32,
    parameter int NS_W  = 30
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cap_req_i,
    input  logic             overwrite_i,
    input  logic             consume_i,
    input  logic [SEC_W-1:0] time_sec_i,
    input  logic [NS_W-1:0]  time_nsec_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [NS_W-1:0]  nsec_o,
    output logic             empty_o,
    output logic             drop_o,
    output logic             cap_take_o
);
    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  nsec;
        logic             empty;
        logic             drop;
    } hold_t;

    hold_t st_d, st_q;
    logic  take;

    always_comb begin
        st_d = st_q;
        take = cap_req_i & (st_q.empty | overwrite_i | consume_i);
        if (consume_i) begin
            st_d.empty = 1'b1;
            st_d.drop  = 1'b0;
        end
        if (take) begin
            st_d.sec   = time_sec_i;
            st_d.nsec  = time_nsec_i;
            st_d.empty = 1'b0;
        end else if (cap_req_i) begin
            st_d.drop  = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.sec   <= '0;
            st_q.nsec  <= '0;
            st_q.empty <= 1'b1;
            st_q.drop  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o      = st_q.sec;
    assign nsec_o     = st_q.nsec;
    assign empty_o    = st_q.empty;
    assign drop_o     = st_q.drop;
    assign cap_take_o = take;
endmodule

// File: rtl/tsc_read_port.sv
module tsc_read_port
    import tsc_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    rd_en_i,
    input  rd_sel_e rd_sel_i,
    input  logic    cap_take_i,
    output logic    consume_o
);
    typedef struct packed {
        logic armed;
    } port_t;

    port_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_take_i)
            st_d.armed = 1'b0;
        else if (rd_en_i)
            st_d.armed = (rd_sel_i == SEL_NSEC);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q.armed <= 1'b0;
        else         st_q <= st_d;
    end

    assign consume_o = rd_en_i & (rd_sel_i == SEL_SEC) & st_q.armed;
endmodule

// File: rtl/tsc_read_mux.sv
module tsc_read_mux
    import tsc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int NS_W   = 30,
    parameter int DATA_W = 32
) (
    input  rd_sel_e           rd_sel_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [NS_W-1:0]   nsec_i,
    input  logic              empty_i,
    input  logic              drop_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int FLAG_BIT = DATA_W - 1;
    localparam int DROP_BIT = DATA_W - 2;

    always_comb begin
        data_o = '0;
        if (rd_sel_i == SEL_SEC) begin
            data_o[SEC_W-1:0] = sec_i;
        end else begin
            data_o[NS_W-1:0] = nsec_i;
            data_o[DROP_BIT] = drop_i;
            data_o[FLAG_BIT] = empty_i;
        end
    end
endmodule

// File: rtl/tx_ts_capture.sv
module tx_ts_capture
    import tsc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int NS_W   = 30,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SEC_W-1:0]  time_sec_i,
    input  logic [NS_W-1:0]   time_nsec_i,
    input  logic              sof_i,
    input  logic              ts_req_i,
    input  logic              overwrite_i,
    input  logic              rd_en_i,
    input  logic              rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic             cap_req;
    logic             cap_take;
    logic             consume;
    logic [SEC_W-1:0] hold_sec;
    logic [NS_W-1:0]  hold_nsec;
    logic             hold_empty;
    logic             hold_drop;
    rd_sel_e          sel;

    assign cap_req = sof_i & ts_req_i;
    assign sel     = rd_sel_e'(rd_sel_i);

    tsc_hold #(.SEC_W(SEC_W), .NS_W(NS_W)) u_hold (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cap_req_i   (cap_req),
        .overwrite_i (overwrite_i),
        .consume_i   (consume),
        .time_sec_i  (time_sec_i),
        .time_nsec_i (time_nsec_i),
        .sec_o       (hold_sec),
        .nsec_o      (hold_nsec),
        .empty_o     (hold_empty),
        .drop_o      (hold_drop),
        .cap_take_o  (cap_take)
    );

    tsc_read_port u_port (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_en_i    (rd_en_i),
        .rd_sel_i   (sel),
        .cap_take_i (cap_take),
        .consume_o  (consume)
    );

    tsc_read_mux #(.SEC_W(SEC_W), .NS_W(NS_W), .DATA_W(DATA_W)) u_mux (
        .rd_sel_i (sel),
        .sec_i    (hold_sec),
        .nsec_i   (hold_nsec),
        .empty_i  (hold_empty),
        .drop_i   (hold_drop),
        .data_o   (rd_data_o)
    );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int SEC_W = 32,
    parameter int NS_W  = 30
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sof_i,
    input logic             ts_req_i,
    input logic             overwrite_i,
    input logic             rd_en_i,
    input logic             rd_sel_i,
    input logic [SEC_W-1:0] time_sec_i,
    input logic [NS_W-1:0]  time_nsec_i,
    input logic             consume_i,
    input logic [SEC_W-1:0] sec_i,
    input logic [NS_W-1:0]  nsec_i,
    input logic             empty_i,
    input logic             drop_i
);
    a_r1_empty_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> (empty_i && !drop_i));

    a_r2_no_request_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sof_i && !ts_req_i && !consume_i) |=> ($stable(sec_i) && $stable(nsec_i) && $stable(empty_i)));

    a_r3_capture_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sof_i && ts_req_i && (empty_i || overwrite_i)) |=>
        (!empty_i && sec_i == $past(time_sec_i) && nsec_i == $past(time_nsec_i)));

    a_r4_overwrite_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sof_i && ts_req_i && overwrite_i && !drop_i) |=> !drop_i);

    a_r5_keep_and_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sof_i && ts_req_i && !overwrite_i && !empty_i && !consume_i) |=>
        ($stable(sec_i) && $stable(nsec_i) && drop_i));

    a_r6_consume_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (consume_i && !(sof_i && ts_req_i)) |=> (empty_i && !drop_i));

    a_r7_consume_on_sec_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        consume_i |-> (rd_en_i && rd_sel_i));

    a_r9_consume_and_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (consume_i && sof_i && ts_req_i) |=>
        (!empty_i && !drop_i && nsec_i == $past(time_nsec_i)));
endmodule

bind tx_ts_capture tsc_checker #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof_i),
    .ts_req_i    (ts_req_i),
    .overwrite_i (overwrite_i),
    .rd_en_i     (rd_en_i),
    .rd_sel_i    (rd_sel_i),
    .time_sec_i  (time_sec_i),
    .time_nsec_i (time_nsec_i),
    .consume_i   (consume),
    .sec_i       (hold_sec),
    .nsec_i      (hold_nsec),
    .empty_i     (hold_empty),
    .drop_i      (hold_drop)
);

// File: tb/sim_tx_ts_capture.sv
module sim_tx_ts_capture;
    localparam int CLK_PERIOD = 10;
    localparam int SEC_W  = 32;
    localparam int NS_W   = 30;
    localparam int DATA_W = 32;
    localparam int WATCHDOG = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SEC_W-1:0]  t_sec = '0;
    logic [NS_W-1:0]   t_nsec = '0;
    logic              sof = 1'b0;
    logic              req = 1'b0;
    logic              ovw = 1'b0;
    logic              rd_en = 1'b0;
    logic              rd_sel = 1'b0;
    logic [DATA_W-1:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_ts_capture #(.SEC_W(SEC_W), .NS_W(NS_W), .DATA_W(DATA_W)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .time_sec_i  (t_sec),
        .time_nsec_i (t_nsec),
        .sof_i       (sof),
        .ts_req_i    (req),
        .overwrite_i (ovw),
        .rd_en_i     (rd_en),
        .rd_sel_i    (rd_sel),
        .rd_data_o   (rd_data)
    );

    function automatic logic [DATA_W-1:0] nword(input logic e, input logic d, input int ns);
        return {e, d, ns[NS_W-1:0]};
    endfunction

    // monitor: pops the expected item for every read cycle
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            logic [DATA_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (rd_data !== e) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", t, rd_data, e);
            end
        end
    end

    task automatic frame(input int s, input int ns, input logic r);
        t_sec = s; t_nsec = ns[NS_W-1:0]; sof = 1'b1; req = r;
        @(posedge clk); #1;
        sof = 1'b0; req = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [DATA_W-1:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        rd_en = 1'b1; rd_sel = sel;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        // R1: reset state
        rd(1'b0, 32'h8000_0000, "R1 nsec after reset");
        rd(1'b1, 32'h0, "R1 sec after reset");
        // R2: strobe without request
        frame(5, 100, 1'b0);
        rd(1'b0, 32'h8000_0000, "R2 no request ignored");
        rd(1'b1, 32'h0, "R2 sec unchanged");
        // R3: capture at maximum nanoseconds, then R6 consume
        ovw = 1'b0;
        frame(7, 999_999_999, 1'b1);
        rd(1'b0, nword(1'b0, 1'b0, 999_999_999), "R3 nsec captured");
        rd(1'b1, 32'd7, "R3 sec captured");
        rd(1'b0, nword(1'b1, 1'b0, 999_999_999), "R6 consumed after pair");
        // R5: keep mode drops newer
        frame(10, 50, 1'b1);
        frame(11, 60, 1'b1);
        rd(1'b0, nword(1'b0, 1'b1, 50), "R5 older kept, drop set");
        rd(1'b1, 32'd10, "R5 sec of older kept");
        rd(1'b0, nword(1'b1, 1'b0, 50), "R6 drop cleared by consume");
        // R4: overwrite mode
        ovw = 1'b1;
        frame(20, 70, 1'b1);
        frame(21, 80, 1'b1);
        rd(1'b0, nword(1'b0, 1'b0, 80), "R4 newer replaces, no drop");
        rd(1'b1, 32'd21, "R4 sec newer");
        // R7: lone seconds read
        frame(30, 90, 1'b1);
        rd(1'b1, 32'd30, "R7 lone sec read");
        rd(1'b0, nword(1'b0, 1'b0, 90), "R7 not consumed");
        rd(1'b1, 32'd30, "R6 paired sec read");
        rd(1'b0, nword(1'b1, 1'b0, 90), "R6 consumed");
        // R8: capture between the two reads
        frame(40, 5, 1'b1);
        rd(1'b0, nword(1'b0, 1'b0, 5), "R8 first nsec");
        frame(41, 6, 1'b1);
        rd(1'b1, 32'd41, "R8 sec after intervening capture");
        rd(1'b0, nword(1'b0, 1'b0, 6), "R8 pairing cancelled");
        rd(1'b1, 32'd41, "R8 paired sec");
        rd(1'b0, nword(1'b1, 1'b0, 6), "R8 consumed");
        // R9: consume and capture in one cycle, keep mode
        ovw = 1'b0;
        frame(50, 7, 1'b1);
        rd(1'b0, nword(1'b0, 1'b0, 7), "R9 arm");
        exp_q.push_back(32'd50); tag_q.push_back("R9 sec during capture");
        rd_en = 1'b1; rd_sel = 1'b1;
        t_sec = 51; t_nsec = 8; sof = 1'b1; req = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0; sof = 1'b0; req = 1'b0;
        rd(1'b0, nword(1'b0, 1'b0, 8), "R9 capture accepted");
        rd(1'b1, 32'd51, "R9 sec accepted");
        rd(1'b0, nword(1'b1, 1'b0, 8), "R9 consumed");
        @(posedge clk); #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule